// File: doc/BRIEF.md
# Program Status Polling Read Path

This block is the read-side output selector of a sector-programmed flash memory model. A host read takes place while chip enable and output enable are both low and write enable is high. The block then drives one byte onto the data bus, together with a drive-enable flag. When the access conditions are not met, it releases the bus: the enable flag drops and the data lines are held at zero. Both outputs are registered, so they follow the control pins one clock later.

A write sequencer outside this block reports two things: a busy flag while its internal timer runs, and a strobe with each byte it accepts. The timer runs either for a real programming cycle or after a write attempt that lacked the unlock sequence. While the sequencer is idle, a read returns the array byte presented at `array_data`. While it is busy, a read returns a status word built from the last accepted byte, in which bit 7 is inverted and bit 6 is replaced by a toggle that advances once per read access. Software can therefore detect the end of a programming cycle in either of two ways: by waiting until bit 7 matches the written data, or by waiting until bit 6 stops changing.

Top module: `flash_poll_rdpath`

## Requirements
- R1: `bus_drive` is 1 in the cycle after a clock edge at which `ce_n`=0, `oe_n`=0 and `we_n`=1 were sampled, and 0 after any other combination.
- R2: Whenever `bus_drive` is 0, `bus_data` is all zeros.
- R3: When the busy flag sampled with the access was 0, `bus_data` equals the `array_data` value sampled at that same edge. This includes an access during which busy falls: the true data appears one cycle after the fall.
- R4: When busy was sampled 1, `bus_data[7]` is the inverse of bit 7 of the last byte captured by `load_strobe`.
- R5: When busy was sampled 1, `bus_data[6]` shows a toggle bit. The bit inverts at the start of each read access that begins while busy, and it stays constant for the rest of that access, however many cycles the access lasts.
- R6: When busy was sampled 1, `bus_data[5:0]` equal bits 5:0 of the last captured byte.
- R7: The toggle does not change during accesses made while idle. It also does not change during cycles in which only part of the read condition holds, for example `we_n` low or `oe_n` high.
- R8: A byte presented with `load_strobe` at one clock edge is the byte used by a polling read that starts at the next edge.
- R9: A busy flag caused by a write attempt that lacked the unlock sequence gives the same polling behaviour as a busy flag caused by a real programming cycle.
- R10: After reset, `bus_drive` is 0, the toggle is 0 so that the first busy access reads bit 6 as 1, and the last captured byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| seq_busy | input | 1 | Sequencer timer running (program cycle or rejected write) |
| load_strobe | input | 1 | One-cycle pulse: sequencer accepted a byte |
| load_byte | input | DATA_W | Byte accepted by the sequencer |
| array_data | input | DATA_W | Stored byte at the current address |
| bus_data | output | DATA_W | Read data, zero when released |
| bus_drive | output | 1 | Data bus driven when 1 |

## Verification
If the toggle register is corrupt, the fault shows at the very first busy access after the error: bit 6 either repeats the previous access's value or changes in the middle of an access. A stale last-byte register shows up in bits 7 and 5:0 of the next polling read. A wrong access-edge detector makes the toggle advance during partial or write-enabled cycles, and this becomes visible at the next proper busy read. Each fault is therefore exposed within one access, and the checks compare every busy-read output against a reference toggle and byte that the checks keep for themselves.

// File: rtl/frp_pkg.sv
package frp_pkg;
  localparam int unsigned FRP_DATA_W   = 8;
  localparam int unsigned FRP_SYNC_LEN = 2;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } frp_src_e;
endpackage

// File: rtl/frp_reset_sync.sv
module frp_reset_sync #(
  parameter int unsigned STAGES = frp_pkg::FRP_SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/frp_access_detect.sv
module frp_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_en,
  output logic rd_start
);
  logic rd_q;
  logic rd_d;

  always_comb begin
    rd_en    = ~ce_n & ~oe_n & we_n;
    rd_d     = rd_en;
    rd_start = rd_en & ~rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_d;
  end
endmodule

// File: rtl/frp_toggle.sv
module frp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_start,
  output logic tog_nxt
);
  logic tog_q;
  logic adv_en;

  always_comb begin
    adv_en  = rd_start & busy;
    tog_nxt = adv_en ? ~tog_q : tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (adv_en) tog_q <= tog_nxt;
  end
endmodule

// File: rtl/frp_last_byte.sv
module frp_last_byte #(
  parameter int unsigned DATA_W = frp_pkg::FRP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_strobe,
  input  logic [DATA_W-1:0] load_byte,
  output logic [DATA_W-1:0] last_q
);
  logic [DATA_W-1:0] last_d;

  always_comb begin
    last_d = load_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_q <= '0;
    else if (load_strobe) last_q <= last_d;
  end
endmodule

// File: rtl/frp_out_stage.sv
module frp_out_stage #(
  parameter int unsigned DATA_W = frp_pkg::FRP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              tog,
  input  logic [DATA_W-1:0] last_byte,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive
);
  import frp_pkg::*;

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TGL_BIT  = DATA_W - 2;

  frp_src_e          src;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] data_d;

  for (genvar b = 0; b < DATA_W; b++) begin : g_status
    if (b == POLL_BIT) begin : g_poll
      assign status_word[b] = ~last_byte[b];
    end else if (b == TGL_BIT) begin : g_tgl
      assign status_word[b] = tog;
    end else begin : g_pass
      assign status_word[b] = last_byte[b];
    end
  end

  always_comb begin
    if (!rd_en)    src = SRC_NONE;
    else if (busy) src = SRC_STATUS;
    else           src = SRC_ARRAY;

    unique case (src)
      SRC_STATUS: data_d = status_word;
      SRC_ARRAY:  data_d = array_data;
      default:    data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_data  <= '0;
      bus_drive <= 1'b0;
    end else begin
      bus_data  <= data_d;
      bus_drive <= rd_en;
    end
  end
endmodule

// File: rtl/flash_poll_rdpath.sv
module flash_poll_rdpath #(
  parameter int unsigned DATA_W = frp_pkg::FRP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              seq_busy,
  input  logic              load_strobe,
  input  logic [DATA_W-1:0] load_byte,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive
);
  logic              rst_sync_n;
  logic              rd_en;
  logic              rd_start;
  logic              tog_nxt;
  logic [DATA_W-1:0] last_q;

  frp_reset_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  frp_access_detect i_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .rd_en    (rd_en),
    .rd_start (rd_start)
  );

  frp_toggle i_tog (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .busy     (seq_busy),
    .rd_start (rd_start),
    .tog_nxt  (tog_nxt)
  );

  frp_last_byte #(.DATA_W(DATA_W)) i_last (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_strobe (load_strobe),
    .load_byte   (load_byte),
    .last_q      (last_q)
  );

  frp_out_stage #(.DATA_W(DATA_W)) i_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_en      (rd_en),
    .busy       (seq_busy),
    .tog        (tog_nxt),
    .last_byte  (last_q),
    .array_data (array_data),
    .bus_data   (bus_data),
    .bus_drive  (bus_drive)
  );
endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
  parameter int unsigned DATA_W = frp_pkg::FRP_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              seq_busy,
  input logic              load_strobe,
  input logic [DATA_W-1:0] load_byte,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_drive
);
  localparam int unsigned PB = DATA_W - 1;
  localparam int unsigned TB = DATA_W - 2;

  logic              cond_d;
  logic              busy_d;
  logic              drive_d;
  logic              seen_tog;
  logic [DATA_W-1:0] arr_d;
  logic [DATA_W-1:0] ref_last;
  logic              status_cyc;
  logic              new_acc;

  assign status_cyc = bus_drive & busy_d;
  assign new_acc    = bus_drive & ~drive_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_d   <= 1'b0;
      busy_d   <= 1'b0;
      drive_d  <= 1'b0;
      seen_tog <= 1'b0;
      arr_d    <= '0;
      ref_last <= '0;
    end else begin
      cond_d  <= ~ce_n & ~oe_n & we_n;
      busy_d  <= seq_busy;
      drive_d <= bus_drive;
      arr_d   <= array_data;
      if (load_strobe) ref_last <= load_byte;
      if (status_cyc)  seen_tog <= bus_data[TB];
    end
  end

  // R1
  drive_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive == cond_d);

  // R2
  release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> bus_data == '0);

  // R3
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && !busy_d) |-> bus_data == arr_d);

  // R4
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_cyc |-> bus_data[PB] == ~ref_last[PB]);

  // R6
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_cyc |-> bus_data[TB-1:0] == ref_last[TB-1:0]);

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_cyc && new_acc) |-> bus_data[TB] != seen_tog);

  // R7
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_cyc && !new_acc) |-> bus_data[TB] == seen_tog);
endmodule

bind flash_poll_rdpath frp_checker #(.DATA_W(DATA_W)) i_frp_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .seq_busy    (seq_busy),
  .load_strobe (load_strobe),
  .load_byte   (load_byte),
  .array_data  (array_data),
  .bus_data    (bus_data),
  .bus_drive   (bus_drive)
);

// File: tb/test_flash_poll_rdpath.sv
`timescale 1ns/1ps
module test_flash_poll_rdpath;
  localparam int unsigned DW = 8;
  localparam int unsigned NV = 10;

  logic          clk;
  logic          rst_n;
  logic          ce_n, oe_n, we_n;
  logic          seq_busy;
  logic          load_strobe;
  logic [DW-1:0] load_byte;
  logic [DW-1:0] array_data;
  logic [DW-1:0] bus_data;
  logic          bus_drive;

  int n_run;
  int n_fail;

  // {load_en, load_byte, busy, array_data, expected}
  localparam logic [25:0] VEC [0:NV-1] = '{
    {1'b1, 8'hA5, 1'b0, 8'h3C, 8'h3C},
    {1'b0, 8'h00, 1'b1, 8'h3C, 8'h65},
    {1'b0, 8'h00, 1'b1, 8'h3C, 8'h25},
    {1'b1, 8'h5A, 1'b1, 8'h3C, 8'hDA},
    {1'b0, 8'h00, 1'b1, 8'h3C, 8'h9A},
    {1'b0, 8'h00, 1'b0, 8'h77, 8'h77},
    {1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    {1'b1, 8'hFF, 1'b1, 8'h11, 8'h7F},
    {1'b1, 8'h00, 1'b1, 8'h11, 8'h80},
    {1'b0, 8'h00, 1'b0, 8'hC3, 8'hC3}
  };

  flash_poll_rdpath #(.DATA_W(DW)) i_flash_poll_rdpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .seq_busy    (seq_busy),
    .load_strobe (load_strobe),
    .load_byte   (load_byte),
    .array_data  (array_data),
    .bus_data    (bus_data),
    .bus_drive   (bus_drive)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [DW:0] got, input logic [DW:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_load(input logic [DW-1:0] b);
    @(negedge clk);
    load_strobe = 1'b1;
    load_byte   = b;
    @(negedge clk);
    load_strobe = 1'b0;
  endtask

  task automatic read_once(output logic [DW:0] res);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    res = {bus_drive, bus_data};
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW:0] r;
    n_run = 0; n_fail = 0;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    seq_busy = 1'b0; load_strobe = 1'b0;
    load_byte = '0; array_data = '0;
    apply_reset();

    // R10 R2: reset state
    check("R10 reset drive/data", {bus_drive, bus_data}, {1'b0, 8'h00});

    // Table: R3 idle reads, R4 R5 R6 R8 R9 polling reads
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) do_load(VEC[i][24:17]);
      @(negedge clk);
      seq_busy   = VEC[i][16];
      array_data = VEC[i][15:8];
      read_once(r);
      if (VEC[i][16]) check($sformatf("R4 R5 R6 R9 vec %0d", i), r, {1'b1, VEC[i][7:0]});
      else            check($sformatf("R3 vec %0d", i), r, {1'b1, VEC[i][7:0]});
    end

    // R1 R2 R7: partial conditions while busy; last byte 0x00, toggle 0
    @(negedge clk);
    seq_busy = 1'b1;
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 R2 oe_n high", {bus_drive, bus_data}, {1'b0, 8'h00});
    oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    check("R1 we_n low", {bus_drive, bus_data}, {1'b0, 8'h00});
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    read_once(r);
    check("R7 single advance after partials", r, {1'b1, 8'hC0});

    // R5 R3: held access, stable toggle, then busy falls mid-access
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check("R5 held access first", {bus_drive, bus_data}, {1'b1, 8'h80});
    @(negedge clk);
    check("R5 held access stable", {bus_drive, bus_data}, {1'b1, 8'h80});
    seq_busy = 1'b0; array_data = 8'h5E;
    @(negedge clk);
    check("R3 busy falls mid-access", {bus_drive, bus_data}, {1'b1, 8'h5E});
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    check("R2 released after access", {bus_drive, bus_data}, {1'b0, 8'h00});

    // R7: idle accesses hold the toggle
    array_data = 8'h11;
    read_once(r);
    check("R3 idle read a", r, {1'b1, 8'h11});
    read_once(r);
    check("R3 idle read b", r, {1'b1, 8'h11});
    seq_busy = 1'b1;
    read_once(r);
    check("R7 toggle held over idle reads", r, {1'b1, 8'hC0});

    // R8: polling straight after a load
    do_load(8'h3C);
    read_once(r);
    check("R8 immediate poll", r, {1'b1, 8'hBC});
    read_once(r);
    check("R8 R5 second poll", r, {1'b1, 8'hFC});

    // R10: reset clears toggle and last byte
    apply_reset();
    check("R10 drive after reset", {bus_drive, bus_data}, {1'b0, 8'h00});
    seq_busy = 1'b1;
    read_once(r);
    check("R10 first busy read", r, {1'b1, 8'hC0});
    seq_busy = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule